// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Output

This block is a 2048-entry, 9-bit first-in first-out buffer between two independent, free-running clocks. The clocks may be unrelated or may be the same clock. A producer stores words on the write clock using two write enables and an input-ready flag. A consumer takes words on the read clock using two read enables, an output enable and an output-ready flag. The oldest stored word moves into the output register by itself, so a consumer sees the head word before it asks for it. Output-ready high means that this register holds a valid word.

The write side also drives a half-full flag and an almost-full/almost-empty flag. The distance N that defines "almost" is 256 after reset. Software-free setup is possible: while the program-enable input is high, a write-clock edge loads N from the data inputs. The reset input is active low and asynchronous to both clocks. It must stay low through at least four edges of each clock.

Pointers cross between the clock domains as Gray codes through two-stage synchronizers. Each domain has its own small state machine. The write machine has two states. WS_HOLD is held after reset, and the transition hold-to-run happens on the first write-clock edge after the local reset synchronizer releases. WS_RUN is the working state and allows stores. The read machine has three states. RS_HOLD is held after reset and passes to RS_EMPTY on the next read-clock edge. RS_EMPTY means the output register is empty, and the transition empty-to-valid happens when a stored word is fetched without a request. RS_VALID means the output register holds a word. Its transitions are: valid-to-valid on a consume when another stored word is ready, or on a cycle without a consume; and valid-to-empty on a consume when no stored word is left.

Top module: `dual_clock_ft_fifo`

## Requirements
- R1: Words leave in the order they were stored, bit for bit, with no inversion. The buffer can hold up to 2048 words of 9 bits.
- R2: A word is stored on a rising write-clock edge only when wr_en_a, wr_en_b and in_ready are all high and prog_en is low.
- R3: A word is consumed on a rising read-clock edge only when rd_en_a, rd_en_b, out_en and out_ready are all high. While no consume happens, out_ready stays high and rd_data does not change.
- R4: When the buffer is empty, the first stored word reaches rd_data, and out_ready rises, with all read enables and out_en held low.
- R5: in_ready falls exactly when 2048 words are held. The word in the output register counts toward this total. in_ready rises within six write-clock cycles after reset is released. in_ready changes only on the write clock, and out_ready changes only on the read clock.
- R6: As soon as rst_n goes low, and for as long as it stays low, in_ready, out_ready and half_full are low and almost_flag is high. After release, the buffer is empty.
- R7: half_full is high exactly when at least 1025 words are held.
- R8: almost_flag is high exactly when the held count is at most N or at least 2048 − N. N is 256 after reset.
- R9: A write-clock edge with prog_en high loads N from wr_data and stores no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock, free running |
| rd_clk | input | 1 | Read clock, free running |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| prog_en | input | 1 | Load the almost distance N from wr_data |
| wr_data | input | 9 | Write data, or the new N |
| in_ready | output | 1 | Room for another word (write domain) |
| half_full | output | 1 | At least 1025 words held (write domain) |
| almost_flag | output | 1 | Held count within N of empty or of full (write domain) |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| out_en | input | 1 | Output enable, also required for a consume |
| rd_data | output | 9 | Output register |
| out_ready | output | 1 | Output register holds a valid word (read domain) |

## Verification
The bench uses several input patterns, and each one separates particular faults:

- **Single word, reads off.** One word is written while every read input is low. This separates true fall-through from a design that waits for a request.
- **Partial read enables.** Read enables are raised while out_en, or one of the enables, stays low. This shows whether a consume needs all three conditions.
- **Straight fill, then drain.** The buffer is filled with reads disabled until in_ready drops. The flags are sampled at both sides of every threshold, and extra writes are pushed at the full boundary. This exposes off-by-one limits in half_full, almost_flag and the full count; overflow shows up in the drained sequence.
- **Reprogrammed N.** A write with prog_en high is checked to store nothing and to move the almost thresholds.
- **Random phase and mid-traffic reset.** Random enables on both ports with unrelated clock periods exercise pointer crossing under partial and full occupancy. The reset is applied in the middle of traffic.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic {
        WS_HOLD,
        WS_RUN
    } wr_state_t;

    typedef enum logic [1:0] {
        RS_HOLD,
        RS_EMPTY,
        RS_VALID
    } rd_state_t;

endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] gray_out
);

    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= {stg_q[STAGES-2:0], gray_in};
        end
    end

    assign gray_out = stg_q[STAGES-1];

endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int DW = 9,
    parameter int AW = 11
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int DW         = 9,
    parameter int AW         = 11,
    parameter int SYNC       = 2,
    parameter int ALMOST_RST = 256
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          en_a,
    input  logic          en_b,
    input  logic          prog,
    input  logic [DW-1:0] din,
    input  logic [AW:0]   rptr_gray_sync,
    output logic [AW:0]   wptr_gray,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic          ready,
    output logic          half,
    output logic          almost
);

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int NW    = (DW < AW) ? DW : AW;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2 + 1);

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    logic [SYNC-1:0] rst_sr;
    logic            lrst_n;
    wr_state_t       state_q, state_d;
    logic [PW-1:0]   wbin_q;
    logic [PW-1:0]   held;
    logic [PW-1:0]   n_ext;
    logic [NW-1:0]   n_q;
    logic            accept;

    // local reset: asynchronous assert, synchronous release
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            rst_sr <= '0;
        end else begin
            rst_sr <= {rst_sr[SYNC-2:0], 1'b1};
        end
    end
    assign lrst_n = rst_sr[SYNC-1];

    // state register
    always_ff @(posedge clk or negedge lrst_n) begin
        if (!lrst_n) begin
            state_q <= WS_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            WS_HOLD: state_d = WS_RUN;
            WS_RUN:  state_d = WS_RUN;
            default: state_d = WS_HOLD;
        endcase
    end

    // outputs and flags
    always_comb begin
        held   = wbin_q - from_gray(rptr_gray_sync);
        n_ext  = {{(PW - NW){1'b0}}, n_q};
        ready  = (state_q == WS_RUN) && (held != DEPTH_P);
        accept = ready && en_a && en_b && !prog;
        half   = (held >= HALF_P);
        almost = (held <= n_ext) || (held >= (DEPTH_P - n_ext));
    end

    always_ff @(posedge clk or negedge lrst_n) begin
        if (!lrst_n) begin
            wbin_q    <= '0;
            wptr_gray <= '0;
            n_q       <= NW'(ALMOST_RST);
        end else begin
            if (accept) begin
                wbin_q    <= wbin_q + 1'b1;
                wptr_gray <= to_gray(wbin_q + 1'b1);
            end
            if (prog) begin
                n_q <= din[NW-1:0];
            end
        end
    end

    assign ram_we    = accept;
    assign ram_waddr = wbin_q[AW-1:0];

endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int AW   = 11,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          en_a,
    input  logic          en_b,
    input  logic          oe,
    input  logic [AW:0]   wptr_gray_sync,
    output logic [AW:0]   rptr_gray,
    output logic          ram_re,
    output logic [AW-1:0] ram_raddr,
    output logic          valid
);

    localparam int PW = AW + 1;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    logic [SYNC-1:0] rst_sr;
    logic            lrst_n;
    rd_state_t       state_q, state_d;
    logic [PW-1:0]   fetch_q;
    logic [PW-1:0]   cons_q;
    logic            stored;
    logic            take;
    logic            load;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            rst_sr <= '0;
        end else begin
            rst_sr <= {rst_sr[SYNC-2:0], 1'b1};
        end
    end
    assign lrst_n = rst_sr[SYNC-1];

    // state register
    always_ff @(posedge clk or negedge lrst_n) begin
        if (!lrst_n) begin
            state_q <= RS_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs of the state machine
    always_comb begin
        stored = (fetch_q != from_gray(wptr_gray_sync));
        valid  = (state_q == RS_VALID);
        take   = valid && en_a && en_b && oe;
        load   = stored && ((state_q == RS_EMPTY) || take);
    end

    always_comb begin
        unique case (state_q)
            RS_HOLD:  state_d = RS_EMPTY;
            RS_EMPTY: state_d = load ? RS_VALID : RS_EMPTY;
            RS_VALID: state_d = (take && !stored) ? RS_EMPTY : RS_VALID;
            default:  state_d = RS_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge lrst_n) begin
        if (!lrst_n) begin
            fetch_q   <= '0;
            cons_q    <= '0;
            rptr_gray <= '0;
        end else begin
            if (load) begin
                fetch_q <= fetch_q + 1'b1;
            end
            if (take) begin
                cons_q    <= cons_q + 1'b1;
                rptr_gray <= to_gray(cons_q + 1'b1);
            end
        end
    end

    assign ram_re    = load;
    assign ram_raddr = fetch_q[AW-1:0];

endmodule

// File: rtl/dual_clock_ft_fifo.sv
module dual_clock_ft_fifo #(
    parameter int DW         = 9,
    parameter int AW         = 11,
    parameter int SYNC       = 2,
    parameter int ALMOST_RST = 256
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en_a,
    input  logic          wr_en_b,
    input  logic          prog_en,
    input  logic [DW-1:0] wr_data,
    output logic          in_ready,
    output logic          half_full,
    output logic          almost_flag,
    input  logic          rd_en_a,
    input  logic          rd_en_b,
    input  logic          out_en,
    output logic [DW-1:0] rd_data,
    output logic          out_ready
);

    localparam int PW = AW + 1;

    logic [PW-1:0] wgray, wgray_rd;
    logic [PW-1:0] rgray, rgray_wr;
    logic          ram_we, ram_re;
    logic [AW-1:0] waddr, raddr;

    dcf_wr_side #(
        .DW(DW), .AW(AW), .SYNC(SYNC), .ALMOST_RST(ALMOST_RST)
    ) u_wr (
        .clk            (wr_clk),
        .arst_n         (rst_n),
        .en_a           (wr_en_a),
        .en_b           (wr_en_b),
        .prog           (prog_en),
        .din            (wr_data),
        .rptr_gray_sync (rgray_wr),
        .wptr_gray      (wgray),
        .ram_we         (ram_we),
        .ram_waddr      (waddr),
        .ready          (in_ready),
        .half           (half_full),
        .almost         (almost_flag)
    );

    dcf_gray_sync #(.W(PW), .STAGES(SYNC)) u_w2r (
        .clk      (rd_clk),
        .arst_n   (rst_n),
        .gray_in  (wgray),
        .gray_out (wgray_rd)
    );

    dcf_gray_sync #(.W(PW), .STAGES(SYNC)) u_r2w (
        .clk      (wr_clk),
        .arst_n   (rst_n),
        .gray_in  (rgray),
        .gray_out (rgray_wr)
    );

    dcf_rd_side #(.AW(AW), .SYNC(SYNC)) u_rd (
        .clk            (rd_clk),
        .arst_n         (rst_n),
        .en_a           (rd_en_a),
        .en_b           (rd_en_b),
        .oe             (out_en),
        .wptr_gray_sync (wgray_rd),
        .rptr_gray      (rgray),
        .ram_re         (ram_re),
        .ram_raddr      (raddr),
        .valid          (out_ready)
    );

    dcf_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk  (wr_clk),
        .we    (ram_we),
        .waddr (waddr),
        .wdata (wr_data),
        .rclk  (rd_clk),
        .re    (ram_re),
        .raddr (raddr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int DW = 9
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en_a,
    input logic          wr_en_b,
    input logic          prog_en,
    input logic          in_ready,
    input logic          half_full,
    input logic          almost_flag,
    input logic          rd_en_a,
    input logic          rd_en_b,
    input logic          out_en,
    input logic [DW-1:0] rd_data,
    input logic          out_ready
);

    // R6
    always @(posedge wr_clk) begin
        if (!rst_n) begin
            reset_wflags_chk: assert (!in_ready && !half_full && almost_flag)
                else $error("write-side flags wrong during reset");
        end
    end

    // R6
    always @(posedge rd_clk) begin
        if (!rst_n) begin
            reset_rflag_chk: assert (!out_ready)
                else $error("out_ready high during reset");
        end
    end

    // R5
    ir_fall_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(wr_en_a && wr_en_b && !prog_en))
        else $error("in_ready fell without a store");

    // R3
    or_fall_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $fell(out_ready) |-> $past(rd_en_a && rd_en_b && out_en))
        else $error("out_ready fell without a consume");

    // R3
    hold_data_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (out_ready && !(rd_en_a && rd_en_b && out_en)) |=> (out_ready && $stable(rd_data)))
        else $error("output word changed without a consume");

    // R7
    hf_rise_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $rose(half_full) |-> $past(wr_en_a && wr_en_b && in_ready && !prog_en))
        else $error("half_full rose without a store");

endmodule

bind dual_clock_ft_fifo dcf_checker #(.DW(DW)) u_chk (
    .wr_clk      (wr_clk),
    .rd_clk      (rd_clk),
    .rst_n       (rst_n),
    .wr_en_a     (wr_en_a),
    .wr_en_b     (wr_en_b),
    .prog_en     (prog_en),
    .in_ready    (in_ready),
    .half_full   (half_full),
    .almost_flag (almost_flag),
    .rd_en_a     (rd_en_a),
    .rd_en_b     (rd_en_b),
    .out_en      (out_en),
    .rd_data     (rd_data),
    .out_ready   (out_ready)
);

// File: tb/tb_dual_clock_ft_fifo.sv
`timescale 1ns/100ps
module tb_dual_clock_ft_fifo;

    localparam int DEPTH = 2048;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       rst_n  = 1'b0;
    logic       wr_en_a = 1'b0, wr_en_b = 1'b0, prog_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       rd_en_a = 1'b0, rd_en_b = 1'b0, out_en = 1'b0;
    logic       in_ready, half_full, almost_flag, out_ready;
    logic [8:0] rd_data;

    int         n_chk = 0;
    int         n_err = 0;
    logic [8:0] mq[$];
    int         almost_n = 256;

    always #2.0 wr_clk = ~wr_clk;
    always #3.3 rd_clk = ~rd_clk;

    dual_clock_ft_fifo dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .prog_en(prog_en), .wr_data(wr_data),
        .in_ready(in_ready), .half_full(half_full), .almost_flag(almost_flag),
        .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en(out_en),
        .rd_data(rd_data), .out_ready(out_ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_half(input int lvl);
        return lvl >= 1025;
    endfunction

    function automatic bit exp_almost(input int lvl);
        return (lvl <= almost_n) || (lvl >= DEPTH - almost_n);
    endfunction

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // one write-clock step; a store is predicted from the flag before the edge
    task automatic wr_step(input bit a, input bit b, input bit pg, input logic [8:0] d);
        @(negedge wr_clk);
        wr_en_a = a; wr_en_b = b; prog_en = pg; wr_data = d;
        if (pg) almost_n = int'(d);
        else if (in_ready && a && b) mq.push_back(d);
    endtask

    task automatic rd_step(input bit a, input bit b, input bit o);
        @(negedge rd_clk);
        rd_en_a = a; rd_en_b = b; out_en = o;
        if (out_ready && a && b && o) begin
            if (mq.size() == 0) begin
                check(1'b0, "R3 consume while model empty", 1, 0);
            end else begin
                check(rd_data == mq[0], "R1 word order", int'(rd_data), int'(mq[0]));
                void'(mq.pop_front());
            end
        end
    endtask

    task automatic drain();
        for (int k = 0; k < 20000 && mq.size() != 0; k++) rd_step(1, 1, 1);
        repeat (10) rd_step(1, 1, 1);
        rd_step(0, 0, 0);
        check(mq.size() == 0, "R1 all words delivered", mq.size(), 0);
        check(out_ready == 1'b0, "R3 out_ready low after drain", out_ready, 0);
        repeat (8) @(negedge wr_clk);
    endtask

    task automatic do_reset();
        @(negedge wr_clk);
        #1;
        rst_n = 1'b0;
        #0.5;
        check(in_ready == 1'b0, "R6 in_ready low in reset", in_ready, 0);
        check(out_ready == 1'b0, "R6 out_ready low in reset", out_ready, 0);
        check(half_full == 1'b0, "R6 half_full low in reset", half_full, 0);
        check(almost_flag == 1'b1, "R6 almost_flag high in reset", almost_flag, 1);
        wr_en_a = 0; wr_en_b = 0; prog_en = 0; rd_en_a = 0; rd_en_b = 0; out_en = 0;
        repeat (12) @(negedge wr_clk);
        rst_n = 1'b1;
        mq.delete();
        almost_n = 256;
        repeat (6) @(negedge wr_clk);
        check(in_ready == 1'b1, "R5 in_ready up within six clocks", in_ready, 1);
    endtask

    // watchdog
    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));

        // reset state
        repeat (3) @(negedge wr_clk);
        check(in_ready == 1'b0, "R6 in_ready in reset", in_ready, 0);
        check(out_ready == 1'b0, "R6 out_ready in reset", out_ready, 0);
        check(half_full == 1'b0, "R6 half_full in reset", half_full, 0);
        check(almost_flag == 1'b1, "R6 almost_flag in reset", almost_flag, 1);
        repeat (8) @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (6) @(negedge wr_clk);
        check(in_ready == 1'b1, "R5 in_ready after release", in_ready, 1);

        // fall-through with reads off
        wr_step(1, 1, 0, 9'h1A5);
        wr_step(0, 0, 0, 9'h000);
        repeat (10) @(negedge rd_clk);
        check(out_ready == 1'b1, "R4 first word falls through", out_ready, 1);
        check(rd_data == 9'h1A5, "R4 fall-through data", int'(rd_data), 'h1A5);

        // consume needs all three read inputs
        repeat (4) rd_step(1, 1, 0);
        repeat (4) rd_step(1, 0, 1);
        repeat (4) rd_step(0, 1, 1);
        @(negedge rd_clk);
        check(out_ready == 1'b1, "R3 no consume without all enables", out_ready, 1);
        check(rd_data == 9'h1A5, "R3 word held", int'(rd_data), 'h1A5);

        // one write enable alone stores nothing
        wr_step(1, 0, 0, 9'h055);
        wr_step(0, 1, 0, 9'h0AA);
        wr_step(0, 0, 0, 9'h000);
        drain();

        // straight fill with flag thresholds
        begin
            int lvl;
            for (int k = 0; k < 4000; k++) begin
                @(negedge wr_clk);
                lvl = mq.size();
                if (lvl inside {0, 1, 256, 257, 1024, 1025, 1791, 1792, 2047, 2048}) begin
                    check(half_full == exp_half(lvl), $sformatf("R7 half_full at %0d", lvl),
                          half_full, exp_half(lvl));
                    check(almost_flag == exp_almost(lvl), $sformatf("R8 almost_flag at %0d", lvl),
                          almost_flag, exp_almost(lvl));
                end
                if (!in_ready) break;
                wr_en_a = 1; wr_en_b = 1; wr_data = 9'($urandom);
                mq.push_back(wr_data);
            end
            check(mq.size() == DEPTH, "R5 in_ready falls at 2048 held", mq.size(), DEPTH);
        end
        repeat (6) wr_step(1, 1, 0, 9'h1FF);
        check(in_ready == 1'b0, "R2 still full after blocked writes", in_ready, 0);
        wr_step(0, 0, 0, 9'h000);
        drain();

        // program N = 16; that cycle stores nothing
        wr_step(1, 1, 1, 9'd16);
        wr_step(0, 0, 0, 9'd0);
        repeat (10) @(negedge rd_clk);
        check(out_ready == 1'b0, "R9 program cycle stores no word", out_ready, 0);
        @(negedge wr_clk);
        check(almost_flag == 1'b1, "R9 almost at 0 with N=16", almost_flag, 1);
        repeat (16) wr_step(1, 1, 0, 9'($urandom));
        wr_step(0, 0, 0, 9'd0);
        check(almost_flag == 1'b1, "R9 almost at 16 with N=16", almost_flag, 1);
        wr_step(1, 1, 0, 9'h033);
        wr_step(0, 0, 0, 9'd0);
        check(almost_flag == 1'b0, "R9 not almost at 17 with N=16", almost_flag, 0);
        drain();
        wr_step(0, 0, 1, 9'd256);
        wr_step(0, 0, 0, 9'd0);

        // reset in the middle of traffic
        repeat (40) wr_step(1, 1, 0, 9'($urandom));
        wr_step(0, 0, 0, 9'd0);
        do_reset();
        repeat (10) @(negedge rd_clk);
        check(out_ready == 1'b0, "R6 buffer empty after reset", out_ready, 0);
        check(almost_flag == 1'b1, "R8 almost after reset", almost_flag, 1);

        // random traffic on both ports
        fork
            begin
                repeat (3000) wr_step(($urandom % 4) != 0, ($urandom % 4) != 0, 1'b0, 9'($urandom));
                wr_step(0, 0, 0, 9'd0);
            end
            begin
                repeat (2200) rd_step(($urandom % 4) != 0, ($urandom % 5) != 0, ($urandom % 4) != 0);
            end
        join
        drain();

        summary();
        $finish;
    end

endmodule